// File: doc/BRIEF.md
# Extended State Save Sequencer

This block carries out one save of the processor's extended register state to a memory area. A start pulse latches the request, which is a pair of 64-bit mask registers, the enabled-feature control register, the in-use bitmap, a 64-byte-aligned base address and a table that gives the byte offset and word length of every extended component. From these it forms the requested map, then walks the requested components in a fixed order and issues one 64-bit word write per cycle to a simple valid/ready write port.

The floating-point stack image and the vector registers go to the legacy region at fixed places. The control/status word and its mask share one word at byte 24 and have their own rule for when they are stored. Each extended component goes to the offset its table entry gives. Before any write, the sequencer reads the state-present header word at byte 512. It writes that word back last as a merge, so bits outside the requested map keep their old values. Register contents come from a per-component source port that the sequencer indexes by component and word.

Top module: `state_save_seq`

## Requirements
- R1: The requested map is `feat_en_i & {req_hi_i[31:0], req_lo_i[31:0]}`. Bits 63:32 of `req_hi_i` and `req_lo_i` have no effect on any write.
- R2: Component i (i < NCOMP) has its words written if and only if bit i of the requested map is set. Nothing else from the map triggers a component write.
- R3: Component 0 is written as words 0..19 at `base + 8*w`, except word 3. Component 1 is written as 32 words at `base + 160 + 8*w`. In both cases the data is `src_data_i`, and `src_comp_o`/`src_word_o` give the component and word.
- R4: The control/status word (`fpctl_i`) is written to `base + 24` exactly when bit 1 or bit 2 of the map is set. Writing component 1 never covers byte 24.
- R5: Extended component c (2 ≤ c < NCOMP) is written as words `w < len[c]` at `base + off[c] + 8*w`. A zero length writes nothing.
- R6: Bytes 464..511 relative to the base are never written.
- R7: Exactly one read, of `base + 512`, happens before any write. The last write of the operation goes to `base + 512` with data `(old & ~map) | (in_use & map)` over all 64 bits. No other header word is written.
- R8: Writes are issued in this order: component 0, component 1, the control word, the extended components in ascending index, and then the header.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, the write stays pending with an unchanged address.
- R10: `done_o` is high for exactly one cycle, in the cycle after the header write is accepted. `busy_o` is high during every read and write.
- R11: A start pulse while `busy_o` is high is ignored: the operation produces no extra writes and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one save operation |
| req_hi_i | input | 64 | Upper request mask register; only bits 31:0 used |
| req_lo_i | input | 64 | Lower request mask register; only bits 31:0 used |
| feat_en_i | input | 64 | Enabled-feature control register |
| in_use_i | input | 64 | In-use bitmap |
| base_i | input | AW | Save area base, 64-byte aligned |
| fpctl_i | input | 64 | Control/status word with its mask |
| ext_off_i | input | NEXT x OFF_W | Byte offsets; entry k is component k+2 |
| ext_len_i | input | NEXT x LEN_W | Lengths in words; entry k is component k+2 |
| src_comp_o | output | CW | Component being read from the register source |
| src_word_o | output | LEN_W | Word index within that component |
| src_data_i | input | 64 | Register source data for the selected word |
| rd_valid_o | output | 1 | Header read request |
| rd_addr_o | output | AW | Header read address |
| rd_ready_i | input | 1 | Read accepted; data valid in the same cycle |
| rd_data_i | input | 64 | Header read data |
| wr_valid_o | output | 1 | Write request |
| wr_ready_i | input | 1 | Write accepted |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | 64 | Write data |
| wr_be_o | output | 8 | Byte enables, always all set |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The start pulse is latched at one edge, and the header read is presented in the next cycle. Every later write appears at most one cycle after the previous handshake. The bench therefore compares each write in the cycle of its handshake, sampled at the falling edge, against the front of an expected queue built from the requirements. `done_o` is due exactly one cycle after the header handshake, so the bench checks it on every clock against a flag set when the header write was accepted. After each operation the bench waits 40 more cycles to catch stray writes, then inspects the reserved bytes and the header word in its memory model.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RDH, ST_WR, ST_HDR} ssv_state_e;

  // fixed legacy layout, bytes/words from base
  localparam int FP_WORDS  = 20;
  localparam int CTL_WORD  = 3;
  localparam int CTL_BYTE  = 24;
  localparam int VEC_BYTE  = 160;
  localparam int VEC_WORDS = 32;
  localparam int HDR_BYTE  = 512;
  localparam int GAP_LO    = 464;
  localparam int GAP_HI    = 511;

  // segment walk order
  localparam int SEG_FP   = 0;
  localparam int SEG_VEC  = 1;
  localparam int SEG_CTL  = 2;
  localparam int SEG_EXT0 = 3;
endpackage

// File: rtl/ssv_reqmap.sv
module ssv_reqmap (
  input  logic [63:0] feat_en_i,
  input  logic [63:0] req_hi_i,
  input  logic [63:0] req_lo_i,
  output logic [63:0] map_o
);
  // upper register halves are architecturally ignored
  logic unused_upper;
  assign unused_upper = ^{req_hi_i[63:32], req_lo_i[63:32]};
  assign map_o = feat_en_i & {req_hi_i[31:0], req_lo_i[31:0]};
endmodule

// File: rtl/ssv_seg_pick.sv
module ssv_seg_pick import ssv_pkg::*; #(
  parameter  int NCOMP = 8,
  localparam int NEXT  = NCOMP - 2,
  localparam int NSEG  = NCOMP + 1,
  localparam int SW    = $clog2(NSEG + 1)
) (
  input  logic [NCOMP-1:0] map_i,
  input  logic [NEXT-1:0]  ext_nz_i,
  input  logic [SW-1:0]    from_i,
  output logic             found_o,
  output logic [SW-1:0]    seg_o
);
  logic [NSEG-1:0] seg_en;

  assign seg_en[SEG_FP]  = map_i[0];
  assign seg_en[SEG_VEC] = map_i[1];
  assign seg_en[SEG_CTL] = map_i[1] | map_i[2];

  for (genvar s = SEG_EXT0; s < NSEG; s++) begin : g_ext_en
    assign seg_en[s] = map_i[s-1] & ext_nz_i[s-SEG_EXT0];
  end

  // lowest enabled segment at or above from_i
  always_comb begin
    found_o = 1'b0;
    seg_o   = '0;
    for (int s = NSEG - 1; s >= 0; s--) begin
      if (seg_en[s] && (SW'(s) >= from_i)) begin
        found_o = 1'b1;
        seg_o   = SW'(s);
      end
    end
  end
endmodule

// File: rtl/ssv_addr.sv
module ssv_addr import ssv_pkg::*; #(
  parameter  int NCOMP = 8,
  parameter  int AW    = 32,
  parameter  int OFF_W = 16,
  parameter  int LEN_W = 8,
  localparam int NEXT  = NCOMP - 2,
  localparam int NSEG  = NCOMP + 1,
  localparam int SW    = $clog2(NSEG + 1),
  localparam int CW    = $clog2(NCOMP)
) (
  input  logic [SW-1:0]                seg_i,
  input  logic [LEN_W-1:0]             word_i,
  input  logic [AW-1:0]                base_i,
  input  logic [NEXT-1:0][OFF_W-1:0]   off_i,
  input  logic [NEXT-1:0][LEN_W-1:0]   len_i,
  output logic [AW-1:0]                addr_o,
  output logic [LEN_W-1:0]             len_o,
  output logic [CW-1:0]                comp_o
);
  logic [AW-1:0] seg_off;

  always_comb begin
    seg_off = '0;
    len_o   = '0;
    comp_o  = '0;
    unique case (int'(seg_i))
      SEG_FP: begin
        len_o = LEN_W'(FP_WORDS);
      end
      SEG_VEC: begin
        seg_off = AW'(VEC_BYTE);
        len_o   = LEN_W'(VEC_WORDS);
        comp_o  = CW'(1);
      end
      SEG_CTL: begin
        seg_off = AW'(CTL_BYTE);
        len_o   = LEN_W'(1);
        comp_o  = CW'(1);
      end
      default: begin
        for (int k = 0; k < NEXT; k++) begin
          if (int'(seg_i) == k + SEG_EXT0) begin
            seg_off = AW'(off_i[k]);
            len_o   = len_i[k];
            comp_o  = CW'(k + 2);
          end
        end
      end
    endcase
  end

  assign addr_o = base_i + seg_off + AW'({word_i, 3'b000});
endmodule

// File: rtl/state_save_seq.sv
module state_save_seq import ssv_pkg::*; #(
  parameter  int NCOMP = 8,
  parameter  int AW    = 32,
  parameter  int OFF_W = 16,
  parameter  int LEN_W = 8,
  localparam int NEXT  = NCOMP - 2,
  localparam int NSEG  = NCOMP + 1,
  localparam int SW    = $clog2(NSEG + 1),
  localparam int CW    = $clog2(NCOMP)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [63:0]                req_hi_i,
  input  logic [63:0]                req_lo_i,
  input  logic [63:0]                feat_en_i,
  input  logic [63:0]                in_use_i,
  input  logic [AW-1:0]              base_i,
  input  logic [63:0]                fpctl_i,
  input  logic [NEXT-1:0][OFF_W-1:0] ext_off_i,
  input  logic [NEXT-1:0][LEN_W-1:0] ext_len_i,
  output logic [CW-1:0]              src_comp_o,
  output logic [LEN_W-1:0]           src_word_o,
  input  logic [63:0]                src_data_i,
  output logic                       rd_valid_o,
  output logic [AW-1:0]              rd_addr_o,
  input  logic                       rd_ready_i,
  input  logic [63:0]                rd_data_i,
  output logic                       wr_valid_o,
  input  logic                       wr_ready_i,
  output logic [AW-1:0]              wr_addr_o,
  output logic [63:0]                wr_data_o,
  output logic [7:0]                 wr_be_o,
  output logic                       busy_o,
  output logic                       done_o
);
  ssv_state_e                 state_q;
  logic [63:0]                map_q, in_use_q, old_q;
  logic [AW-1:0]              base_q;
  logic [NEXT-1:0][OFF_W-1:0] off_q;
  logic [NEXT-1:0][LEN_W-1:0] len_q;
  logic [SW-1:0]              seg_q;
  logic [LEN_W-1:0]           word_q;
  logic                       done_q;

  logic [63:0]      map_d;
  logic [NEXT-1:0]  ext_nz;
  logic [SW-1:0]    pick_from, pick_seg;
  logic             pick_found;
  logic [AW-1:0]    seg_addr, hdr_addr;
  logic [LEN_W-1:0] seg_len, w_nxt;
  logic             seg_last;
  logic [63:0]      hdr_new;

  ssv_reqmap u_reqmap (
    .feat_en_i (feat_en_i),
    .req_hi_i  (req_hi_i),
    .req_lo_i  (req_lo_i),
    .map_o     (map_d)
  );

  for (genvar k = 0; k < NEXT; k++) begin : g_nz
    assign ext_nz[k] = |len_q[k];
  end

  assign pick_from = (state_q == ST_RDH) ? '0 : seg_q + 1'b1;

  ssv_seg_pick #(.NCOMP(NCOMP)) u_pick (
    .map_i    (map_q[NCOMP-1:0]),
    .ext_nz_i (ext_nz),
    .from_i   (pick_from),
    .found_o  (pick_found),
    .seg_o    (pick_seg)
  );

  ssv_addr #(.NCOMP(NCOMP), .AW(AW), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_addr (
    .seg_i  (seg_q),
    .word_i (word_q),
    .base_i (base_q),
    .off_i  (off_q),
    .len_i  (len_q),
    .addr_o (seg_addr),
    .len_o  (seg_len),
    .comp_o (src_comp_o)
  );

  // control word slot inside the fp image is owned by its own segment
  always_comb begin
    w_nxt = word_q + 1'b1;
    if (seg_q == SW'(SEG_FP) && w_nxt == LEN_W'(CTL_WORD)) w_nxt = word_q + LEN_W'(2);
  end
  assign seg_last = (w_nxt >= seg_len);

  assign hdr_addr = base_q + AW'(HDR_BYTE);
  assign hdr_new  = (old_q & ~map_q) | (in_use_q & map_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      map_q    <= '0;
      in_use_q <= '0;
      old_q    <= '0;
      base_q   <= '0;
      off_q    <= '0;
      len_q    <= '0;
      seg_q    <= '0;
      word_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            map_q    <= map_d;
            in_use_q <= in_use_i;
            base_q   <= base_i;
            off_q    <= ext_off_i;
            len_q    <= ext_len_i;
            state_q  <= ST_RDH;
          end
        end
        ST_RDH: begin
          if (rd_ready_i) begin
            old_q  <= rd_data_i;
            word_q <= '0;
            if (pick_found) begin
              seg_q   <= pick_seg;
              state_q <= ST_WR;
            end else begin
              state_q <= ST_HDR;
            end
          end
        end
        ST_WR: begin
          if (wr_ready_i) begin
            if (!seg_last) begin
              word_q <= w_nxt;
            end else begin
              word_q <= '0;
              if (pick_found) seg_q <= pick_seg;
              else            state_q <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (wr_ready_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid_o = (state_q == ST_RDH);
  assign rd_addr_o  = hdr_addr;
  assign wr_valid_o = (state_q == ST_WR) || (state_q == ST_HDR);
  assign wr_addr_o  = (state_q == ST_HDR) ? hdr_addr : seg_addr;
  assign wr_data_o  = (state_q == ST_HDR) ? hdr_new :
                      (seg_q == SW'(SEG_CTL)) ? fpctl_i : src_data_i;
  assign wr_be_o    = '1;
  assign src_word_o = word_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/ssv_chk.sv
module ssv_chk import ssv_pkg::*; #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_i,
  input logic          done_i,
  input logic          wr_valid_i,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_i,
  input logic          rd_valid_i,
  input logic [AW-1:0] base_i
);
  logic [AW-1:0] rel;
  assign rel = wr_addr_i - base_i;

  // R9
  hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && !wr_ready_i |=> wr_valid_i && $stable(wr_addr_i));

  // R6
  rsv_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> !(rel >= AW'(GAP_LO) && rel <= AW'(GAP_HI)));

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R10
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(wr_valid_i && wr_ready_i && (rel == AW'(HDR_BYTE))));

  // R11
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && start_i |=> $stable(base_i));

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |-> !wr_valid_i && busy_i);
endmodule

bind state_save_seq ssv_chk #(.AW(AW)) u_ssv_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .wr_valid_i (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_i  (wr_addr_o),
  .rd_valid_i (rd_valid_o),
  .base_i     (base_q)
);

// File: tb/state_save_seq_bench.sv
module state_save_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCOMP = 8, AW = 32, OFF_W = 16, LEN_W = 8;
  localparam int NEXT = NCOMP - 2, CW = $clog2(NCOMP);

  logic clk = 0, rst_n = 0, start = 0;
  logic [63:0] req_hi = 0, req_lo = 0, feat_en = 0, in_use = 0, fpctl = 0;
  logic [AW-1:0] base = 32'h0000_4000;
  logic [NEXT-1:0][OFF_W-1:0] ext_off;
  logic [NEXT-1:0][LEN_W-1:0] ext_len;
  logic [CW-1:0] src_comp;
  logic [LEN_W-1:0] src_word;
  logic [63:0] src_data, rd_data, wr_data;
  logic rd_valid, rd_ready = 1, wr_valid, wr_ready = 1, busy, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] wr_be;

  logic [63:0] mem [0:255];
  int n_cmp = 0, n_err = 0, done_cnt = 0;
  bit stall_en = 0, rd_seen = 0, hdr_hs_prev = 0, stall_prev = 0;
  logic [AW-1:0] stall_addr;
  int q_off[$];
  logic [63:0] q_dat[$];
  string q_tag[$];
  logic [63:0] exp_hdr;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] src_val(int c, int w);
    return {8'(c), 8'(w), 48'h5EED_0000_0000} ^ 64'(w * 977 + c * 31);
  endfunction

  assign src_data = src_val(int'(src_comp), int'(src_word));
  assign rd_data  = mem[8'((rd_addr - base) >> 3)];

  state_save_seq u_state_save_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_hi_i(req_hi), .req_lo_i(req_lo),
    .feat_en_i(feat_en), .in_use_i(in_use), .base_i(base), .fpctl_i(fpctl),
    .ext_off_i(ext_off), .ext_len_i(ext_len), .src_comp_o(src_comp), .src_word_o(src_word),
    .src_data_i(src_data), .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready),
    .rd_data_i(rd_data), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_be_o(wr_be), .busy_o(busy), .done_o(done));

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  function automatic void push(int off, logic [63:0] d, string t);
    q_off.push_back(off); q_dat.push_back(d); q_tag.push_back(t);
  endfunction

  // expected write stream from the requirements
  task automatic build(logic [63:0] m);
    if (m[0]) for (int w = 0; w < 20; w++) if (w != 3) push(w*8, src_val(0, w), "R3 R8 fp");
    if (m[1]) for (int w = 0; w < 32; w++) push(160 + w*8, src_val(1, w), "R3 R8 vec");
    if (m[1] | m[2]) push(24, fpctl, "R4 R8 ctl");
    for (int c = 2; c < NCOMP; c++)
      if (m[c]) for (int w = 0; w < int'(ext_len[c-2]); w++)
        push(int'(ext_off[c-2]) + w*8, src_val(c, w), "R5 R8 ext");
    push(512, exp_hdr, "R7 R8 hdr");
  endtask

  // ready drivers
  initial forever begin
    @(posedge clk); #1;
    wr_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    rd_ready = stall_en ? ($urandom_range(0, 1) != 0) : 1'b1;
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == hdr_hs_prev, "R10 done timing", 64'(done), 64'(hdr_hs_prev));
      if (done) done_cnt++;
      hdr_hs_prev = 0;
      if (stall_prev) chk(wr_valid && wr_addr == stall_addr, "R9 held write", 64'(wr_addr), 64'(stall_addr));
      stall_prev = wr_valid && !wr_ready;
      stall_addr = wr_addr;
      if ((wr_valid || rd_valid) && !busy) chk(0, "R10 busy", 64'(busy), 64'd1);
      if (rd_valid && rd_ready) begin
        chk(!rd_seen, "R7 single read", 64'(rd_seen), 64'd0);
        chk(rd_addr - base == 512, "R7 read addr", 64'(rd_addr - base), 64'd512);
        rd_seen = 1;
      end
      if (wr_valid && wr_ready) begin
        automatic int off = int'(wr_addr - base);
        if (!rd_seen) chk(0, "R7 write before read", 64'(off), 64'd512);
        if (off >= 464 && off <= 511) chk(0, "R6 gap written", 64'(off), 64'd0);
        if (wr_be != 8'hFF) chk(0, "R2 byte enables", 64'(wr_be), 64'hFF);
        if (q_off.size() == 0) chk(0, "R11 unexpected write", 64'(off), 64'd0);
        else begin
          automatic int eo = q_off.pop_front();
          automatic logic [63:0] ed = q_dat.pop_front();
          automatic string et = q_tag.pop_front();
          chk(off == eo && wr_data == ed, et, {32'(off), wr_data[31:0]}, {32'(eo), ed[31:0]});
        end
        if (off == 512) hdr_hs_prev = 1;
        if (off >= 0 && off < 2048) mem[off >> 3] = wr_data;
      end
    end
  end

  task automatic run_op(logic [63:0] hi, logic [63:0] lo, logic [63:0] en, logic [63:0] iu,
                        logic [63:0] old, bit stall, bit poke, string tag);
    logic [63:0] m;
    int d0, cnt;
    @(posedge clk); #1;
    stall_en = stall;
    req_hi = hi; req_lo = lo; feat_en = en; in_use = iu;
    fpctl = 64'hF00D_0000_1F80_FFFF ^ lo;
    for (int i = 0; i < 256; i++) mem[i] = 64'hDEAD_BEEF_0000_0000 | 64'(i);
    mem[64] = old;
    m = en & {hi[31:0], lo[31:0]};
    exp_hdr = (old & ~m) | (iu & m);
    q_off.delete(); q_dat.delete(); q_tag.delete();
    build(m);
    rd_seen = 0;
    d0 = done_cnt;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    if (poke) begin
      repeat (8) @(posedge clk);
      #1; start = 1; req_lo = ~lo; req_hi = ~hi;
      @(posedge clk); #1; start = 0;
    end
    cnt = 0;
    while (done_cnt == d0 && cnt < 5000) begin @(posedge clk); cnt++; end
    if (cnt >= 5000) chk(0, {tag, " watchdog"}, 64'(cnt), 64'd0);
    repeat (40) @(posedge clk);
    #1;
    chk(q_off.size() == 0, {tag, " R2 missing writes"}, 64'(q_off.size()), 64'd0);
    chk(done_cnt == d0 + 1, {tag, " R11 one done"}, 64'(done_cnt - d0), 64'd1);
    for (int w = 58; w < 64; w++)
      chk(mem[w] == (64'hDEAD_BEEF_0000_0000 | 64'(w)), {tag, " R6 gap intact"}, mem[w], 64'hDEAD_BEEF_0000_0000 | 64'(w));
    chk(mem[64] == exp_hdr, {tag, " R7 header merge"}, mem[64], exp_hdr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog expired", 0, 0);
    summary();
  end

  initial begin
    for (int k = 0; k < NEXT; k++) begin
      ext_off[k] = OFF_W'(576 + k * 128);
      ext_len[k] = (k == 3) ? '0 : LEN_W'(k + 1);
    end
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_valid && !rd_valid, "R10 reset state", {busy, done, wr_valid, rd_valid}, 0);
    rst_n = 1;
    // full map
    run_op('1, '1, '1, 64'h0F0F_0F0F_0F0F_0F0F, 64'hAAAA_5555_AAAA_5555, 0, 0, "R2 full");
    // only bit 2: control word without vectors
    run_op(0, 64'h4, '1, 64'h4, 64'h0, 0, 0, "R4 bit2");
    // only bit 1: vectors plus control word
    run_op(0, 64'h2, '1, 0, '1, 0, 0, "R4 bit1");
    // upper halves garbage, bit 0 only
    run_op(64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0001, '1, '1, 64'h1234, 0, 0, "R1 upper ignored");
    // sparse enable, zero-length component 5
    run_op('1, '1, 64'h2D, 64'h29, 64'hFFFF_0000_FFFF_0000, 0, 0, "R5 sparse");
    // empty request: header only
    run_op(0, 0, '1, '1, 64'hCAFE_F00D_0000_1111, 0, 0, "R7 empty");
    // high map bit only affects header merge
    run_op(64'h1, 0, '1, 64'h1_0000_0000, 0, 0, 0, "R7 bit32");
    // backpressure with a start poke while busy
    run_op('1, '1, '1, 64'h3C, 64'h5A5A, 1, 1, "R9 R11 stall");
    run_op('1, 64'h8D, 64'hFF, 64'hC3, '1, 1, 0, "R9 stall sparse");
    summary();
  end
endmodule